// File: doc/BRIEF.md
# Hourly Chime and Host Audio Sequencer

This block sits beside a running time-of-day counter and arranges what happens at the top of each hour. When the minute value rolls from 59 to 0 on a seconds tick, it starts a short stored tune on a passive buzzer by presenting a PWM period and an enable. In the same moment it serialises the two temperature characters that the display is showing and sends them to a host over an asynchronous serial transmit line.

The host can answer by streaming audio bytes on the serial receive line. Each well-formed byte becomes a new buzzer period. When the first byte arrives, the block captures the hour, the minute and the temperature, and it shows that copy on its display outputs for as long as playback lasts. Playback ends when no byte has arrived for a set idle time. The display then follows the live inputs again. The clock counter, the PWM generator and the display driver are outside this block.

Top module: `chime_audio_seq`

## Requirements
- R1: After reset, `tx_line` is 1, `pwm_en` is 0 and `pwm_period` is 0, and each display output equals its live input.
- R2: A chime fires on a clock edge where `sec_tick` is 1, `minute_in` is 0, and the minute value sampled at the previous `sec_tick` was 59. A tick at minute 0 that follows a tick at minute 0 does not chime.
- R3: The tune has 16 steps of 2^MEL_SHIFT cycles each. A step counter clears to 0 on the chime edge, and step s drives `pwm_period` for the s-th step, counting from that edge. The step periods, in step order, are 22944, 22944, 15306, 15306, 13636, 13636, 15306, 0, 17189, 17189, 18210, 18210, 20442, 20442, 22944, 0.
- R4: During a step whose period is 0, `pwm_en` is 0. During any other tune step, `pwm_en` is 1.
- R5: The tune is cut off CHIME_LIMIT cycles after the chime edge, even if it is unfinished. From then on, `pwm_period` is 0 and `pwm_en` is 0.
- R6: On a chime, `tx_line` sends `temp_disp[15:8]` and then `temp_disp[7:0]`. Each byte is framed as a 0 start bit, eight data bits sent least significant bit first, and a 1 stop bit. Each bit lasts BAUD_DIV cycles, and the start bit begins on the cycle after the chime edge. The line idles at 1.
- R7: `rx_line` passes through a two-flop synchroniser. A low level starts a frame. Each bit is sampled BAUD_DIV/2 cycles into its period. A frame whose stop bit samples 0 is discarded and has no effect on any output.
- R8: A received byte b sets `pwm_period` to b*256 on the cycle after it completes. `pwm_en` is then 1 if b is nonzero and 0 if b is 0. A received byte takes over from a tune that is playing.
- R9: The first byte of a playback captures `hour_in`, `minute_in` and `temp_in`. The display outputs show those captured values until playback ends.
- R10: Playback ends IDLE_LIMIT cycles after the last received byte. At that point `pwm_en` and `pwm_period` go to 0, and the display outputs follow the live inputs again.
- R11: A chime that occurs during host playback is ignored, as is a chime that falls on the cycle when a received byte completes. No tune starts and no report is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hour_in | input | 5 | Live hour |
| minute_in | input | 6 | Live minute |
| sec_tick | input | 1 | One-cycle pulse once per second |
| temp_in | input | 16 | Live temperature as two characters, high character first |
| rx_line | input | 1 | Serial receive line from the host |
| pwm_period | output | 16 | Buzzer period in clock cycles, 0 when silent |
| pwm_en | output | 1 | Buzzer enable |
| tx_line | output | 1 | Serial transmit line to the host |
| hour_disp | output | 5 | Hour shown on the display |
| minute_disp | output | 6 | Minute shown on the display |
| temp_disp | output | 16 | Temperature shown on the display |

## Verification
The hourly chime and the completion of a received byte can land on the same edge. In that case the byte must win: it must set the tone and start the freeze, and the chime must produce neither a tune nor a report. The bench provokes this by starting an audio frame and counting clock cycles through the synchroniser and the mid-bit sampling, so that a tick at minute 0, placed right after a tick at minute 59, lands on the edge that consumes the stop-bit result. It then checks that `pwm_period` carries the byte and that `tx_line` stays high for several bit times afterwards.

// File: rtl/chime_audio_seq.sv
`timescale 1ns/1ps
module chime_audio_seq #(
  parameter int BAUD_DIV    = 1250,
  parameter int MEL_SHIFT   = 22,
  parameter int CHIME_LIMIT = 360_000_000,
  parameter int IDLE_LIMIT  = 1_200_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  hour_in,
  input  logic [5:0]  minute_in,
  input  logic        sec_tick,
  input  logic [15:0] temp_in,
  input  logic        rx_line,
  output logic [15:0] pwm_period,
  output logic        pwm_en,
  output logic        tx_line,
  output logic [4:0]  hour_disp,
  output logic [5:0]  minute_disp,
  output logic [15:0] temp_disp
);
  localparam int DIV_W = $clog2(BAUD_DIV);
  localparam int HALF  = BAUD_DIV / 2;
  localparam int MEL_W = MEL_SHIFT + 4;
  localparam int LIM_W = $clog2(CHIME_LIMIT);
  localparam int GAP_W = $clog2(IDLE_LIMIT);
  localparam logic [1:0] M_IDLE = 2'd0, M_MEL = 2'd1, M_HOST = 2'd2;

  function automatic logic [15:0] tone_of(input logic [3:0] s);
    case (s)
      4'd0, 4'd1, 4'd14: tone_of = 16'd22944;
      4'd2, 4'd3, 4'd6:  tone_of = 16'd15306;
      4'd4, 4'd5:        tone_of = 16'd13636;
      4'd8, 4'd9:        tone_of = 16'd17189;
      4'd10, 4'd11:      tone_of = 16'd18210;
      4'd12, 4'd13:      tone_of = 16'd20442;
      default:           tone_of = 16'd0;
    endcase
  endfunction

  logic [1:0]       mode;
  logic [5:0]       min_last;
  logic [MEL_W-1:0] mel_cnt;
  logic [LIM_W-1:0] lim_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic [7:0]       host_byte;
  logic [4:0]       snap_h;
  logic [5:0]       snap_m;
  logic [15:0]      snap_t;

  logic             rx_s1, rx_s2, rx_busy, rx_valid;
  logic [DIV_W-1:0] rx_div;
  logic [3:0]       rx_idx;
  logic [7:0]       rx_sr;

  logic             tx_busy;
  logic [DIV_W-1:0] tx_div;
  logic [4:0]       tx_cnt;
  logic [19:0]      tx_sr;

  wire chime_evt = sec_tick && (minute_in == 6'd0) && (min_last == 6'd59);
  wire chime_ok  = chime_evt && !rx_valid && (mode != M_HOST);
  wire frozen    = (mode == M_HOST);

  assign hour_disp   = frozen ? snap_h : hour_in;
  assign minute_disp = frozen ? snap_m : minute_in;
  assign temp_disp   = frozen ? snap_t : temp_in;
  assign pwm_period  = (mode == M_HOST) ? {host_byte, 8'h00} :
                       (mode == M_MEL)  ? tone_of(mel_cnt[MEL_W-1 -: 4]) : 16'd0;
  assign pwm_en      = (mode != M_IDLE) && (pwm_period != 16'd0);
  assign tx_line     = tx_busy ? tx_sr[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) min_last <= 6'd0;
    else if (sec_tick) min_last <= minute_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE; mel_cnt <= '0; lim_cnt <= '0; gap_cnt <= '0;
      host_byte <= 8'd0; snap_h <= '0; snap_m <= '0; snap_t <= '0;
    end else if (rx_valid) begin
      mode <= M_HOST; gap_cnt <= '0; host_byte <= rx_sr; mel_cnt <= '0;
      if (mode != M_HOST) begin
        snap_h <= hour_in; snap_m <= minute_in; snap_t <= temp_in;
      end
    end else if (mode == M_HOST) begin
      if (gap_cnt == GAP_W'(IDLE_LIMIT - 1)) mode <= M_IDLE;
      else gap_cnt <= gap_cnt + 1'b1;
    end else if (mode == M_MEL) begin
      if (lim_cnt == LIM_W'(CHIME_LIMIT - 1) || mel_cnt == '1) begin
        mode <= M_IDLE; mel_cnt <= '0;
      end else begin
        mel_cnt <= mel_cnt + 1'b1; lim_cnt <= lim_cnt + 1'b1;
      end
    end else if (chime_ok) begin
      mode <= M_MEL; mel_cnt <= '0; lim_cnt <= '0;
    end else begin
      mel_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1; rx_s2 <= 1'b1; rx_busy <= 1'b0; rx_valid <= 1'b0;
      rx_div <= '0; rx_idx <= '0; rx_sr <= '0;
    end else begin
      rx_s1 <= rx_line; rx_s2 <= rx_s1; rx_valid <= 1'b0;
      if (!rx_busy) begin
        if (!rx_s2) begin
          rx_busy <= 1'b1; rx_div <= '0; rx_idx <= '0;
        end
      end else begin
        if (rx_div == DIV_W'(BAUD_DIV - 1)) begin
          rx_div <= '0; rx_idx <= rx_idx + 1'b1;
        end else begin
          rx_div <= rx_div + 1'b1;
        end
        if (rx_div == DIV_W'(HALF)) begin
          if (rx_idx == 4'd0) begin
            if (rx_s2) rx_busy <= 1'b0;
          end else if (rx_idx == 4'd9) begin
            rx_busy <= 1'b0; rx_valid <= rx_s2;
          end else begin
            rx_sr <= {rx_s2, rx_sr[7:1]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_div <= '0; tx_cnt <= '0; tx_sr <= '1;
    end else if (chime_ok && !tx_busy) begin
      tx_busy <= 1'b1; tx_div <= '0; tx_cnt <= '0;
      tx_sr <= {1'b1, temp_disp[7:0], 1'b0, 1'b1, temp_disp[15:8], 1'b0};
    end else if (tx_busy) begin
      if (tx_div == DIV_W'(BAUD_DIV - 1)) begin
        tx_div <= '0; tx_sr <= {1'b1, tx_sr[19:1]}; tx_cnt <= tx_cnt + 1'b1;
        if (tx_cnt == 5'd19) tx_busy <= 1'b0;
      end else begin
        tx_div <= tx_div + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chime_audio_seq_chk.sv
`timescale 1ns/1ps
module chime_audio_seq_chk #(
  parameter int CHIME_LIMIT = 100,
  parameter int LIM_W       = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             chime_evt,
  input logic             rx_valid,
  input logic [7:0]       rx_byte,
  input logic             tx_busy,
  input logic [15:0]      pwm_period,
  input logic [4:0]       hour_disp,
  input logic [5:0]       minute_disp,
  input logic [15:0]      temp_disp,
  input logic [LIM_W-1:0] lim_cnt
);
  AST_DISPLAY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) == 2'd2) |->
      ($stable(hour_disp) && $stable(minute_disp) && $stable(temp_disp))); // R9

  AST_BYTE_SETS_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (pwm_period == {$past(rx_byte), 8'h00})); // R8

  AST_HOST_IGNORES_CHIME: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && chime_evt) |=> (mode != 2'd1)); // R11

  AST_REPORT_ON_CHIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> ($past(chime_evt) && !$past(rx_valid))); // R6

  AST_TUNE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> ({1'b0, lim_cnt} < (LIM_W + 1)'(CHIME_LIMIT))); // R5
endmodule

bind chime_audio_seq chime_audio_seq_chk #(.CHIME_LIMIT(CHIME_LIMIT), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .chime_evt(chime_evt), .rx_valid(rx_valid),
  .rx_byte(rx_sr), .tx_busy(tx_busy), .pwm_period(pwm_period), .hour_disp(hour_disp),
  .minute_disp(minute_disp), .temp_disp(temp_disp), .lim_cnt(lim_cnt)
);

// File: tb/chime_audio_seq_tb.sv
`timescale 1ns/1ps
module chime_audio_seq_tb_top;
  localparam int B = 16;
  localparam int H = B / 2;
  localparam int STEP = 8;
  localparam int LIM = 100;
  localparam int IDLE = 400;
  localparam logic [15:0] MEL_EXP [16] = '{16'd22944, 16'd22944, 16'd15306, 16'd15306,
    16'd13636, 16'd13636, 16'd15306, 16'd0, 16'd17189, 16'd17189, 16'd18210, 16'd18210,
    16'd20442, 16'd20442, 16'd22944, 16'd0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] hour_in = 5'd7;
  logic [5:0] minute_in = 6'd58;
  logic sec_tick = 1'b0;
  logic [15:0] temp_in = 16'h3235;
  logic rx_line = 1'b1;
  logic [15:0] pwm_period;
  logic pwm_en, tx_line;
  logic [4:0] hour_disp;
  logic [5:0] minute_disp;
  logic [15:0] temp_disp;
  int errors = 0, checks = 0;
  logic [19:0] tx_bits;

  always #5 clk = ~clk;

  chime_audio_seq #(.BAUD_DIV(B), .MEL_SHIFT(3), .CHIME_LIMIT(LIM), .IDLE_LIMIT(IDLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .hour_in(hour_in), .minute_in(minute_in), .sec_tick(sec_tick),
    .temp_in(temp_in), .rx_line(rx_line), .pwm_period(pwm_period), .pwm_en(pwm_en),
    .tx_line(tx_line), .hour_disp(hour_disp), .minute_disp(minute_disp), .temp_disp(temp_disp));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic [5:0] m);
    @(negedge clk); minute_in = m; sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    @(negedge clk); rx_line = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (B) @(negedge clk); rx_line = b[i];
    end
    repeat (B) @(negedge clk); rx_line = stop;
    repeat (B) @(negedge clk); rx_line = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b1, "R1 tx idle", tx_line, 1);
    chk(pwm_en == 1'b0 && pwm_period == 16'd0, "R1 buzzer off", pwm_period, 0);
    chk(hour_disp == 5'd7 && temp_disp == 16'h3235, "R1 live display", hour_disp, 7);

    // R2: no rollover from 58, then a real rollover
    tick(6'd58); tick(6'd0);
    repeat (3) @(negedge clk);
    chk(pwm_en == 1'b0 && tx_line == 1'b1, "R2 no chime without 59", pwm_en, 0);
    hour_in = 5'd8;
    tick(6'd59); tick(6'd0);
    fork
      begin
        int k = 0;
        for (int s = 0; s < 12; s++) begin
          repeat (STEP * s + 4 - k) @(negedge clk);
          k = STEP * s + 4;
          chk(pwm_period == MEL_EXP[s], $sformatf("R3 tune step %0d", s), pwm_period, MEL_EXP[s]);
          chk(pwm_en == (MEL_EXP[s] != 16'd0), $sformatf("R4 enable step %0d", s), pwm_en, MEL_EXP[s] != 0);
        end
        repeat (LIM - 1 - k) @(negedge clk);
        chk(pwm_period == MEL_EXP[12] && pwm_en, "R5 still playing before limit", pwm_period, MEL_EXP[12]);
        @(negedge clk);
        chk(pwm_period == 16'd0 && !pwm_en, "R5 cut at limit", pwm_period, 0);
      end
      begin
        int k = 0;
        for (int i = 0; i < 20; i++) begin
          repeat (B * i + H - k) @(negedge clk);
          k = B * i + H;
          tx_bits[i] = tx_line;
        end
        repeat (30) @(negedge clk);
        chk(tx_line == 1'b1, "R6 line idles after report", tx_line, 1);
      end
    join
    chk(tx_bits[0] == 0 && tx_bits[9] == 1 && tx_bits[8:1] == 8'h32, "R6 first frame", tx_bits[9:0], {1'b1, 8'h32, 1'b0});
    chk(tx_bits[10] == 0 && tx_bits[19] == 1 && tx_bits[18:11] == 8'h35, "R6 second frame", tx_bits[19:10], {1'b1, 8'h35, 1'b0});

    tick(6'd0);
    repeat (3) @(negedge clk);
    chk(pwm_en == 1'b0 && tx_line == 1'b1, "R2 repeat tick at 0", pwm_en, 0);

    // R7: bad stop bit is dropped
    send_frame(8'h5A, 1'b0);
    repeat (2) @(negedge clk);
    hour_in = 5'd9;
    @(negedge clk);
    chk(pwm_en == 1'b0 && pwm_period == 16'd0, "R7 bad stop no tone", pwm_period, 0);
    chk(hour_disp == 5'd9, "R7 bad stop no freeze", hour_disp, 9);

    // R8 / R9: host audio
    send_frame(8'h37, 1'b1);
    chk(pwm_period == 16'h3700 && pwm_en, "R8 byte tone", pwm_period, 16'h3700);
    hour_in = 5'd10; minute_in = 6'd15; temp_in = 16'h3330;
    @(negedge clk);
    chk(hour_disp == 5'd9 && minute_disp == 6'd0 && temp_disp == 16'h3235, "R9 frozen display",
        {hour_disp, minute_disp, temp_disp}, {5'd9, 6'd0, 16'h3235});

    // R11: chime during playback
    tick(6'd59); tick(6'd0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_line != 1'b1) chk(1'b0, "R11 no report in playback", tx_line, 1);
    end
    chk(pwm_period == 16'h3700, "R11 tone kept in playback", pwm_period, 16'h3700);

    send_frame(8'h00, 1'b1);
    chk(pwm_en == 1'b0 && pwm_period == 16'd0, "R8 zero byte silent", pwm_period, 0);
    chk(hour_disp == 5'd9, "R9 still frozen after second byte", hour_disp, 9);

    // R10: idle timeout
    repeat (IDLE - 10) @(negedge clk);
    chk(hour_disp == 5'd9, "R10 frozen before timeout", hour_disp, 9);
    repeat (10) @(negedge clk);
    chk(hour_disp == 5'd10 && minute_disp == 6'd0 && temp_disp == 16'h3330, "R10 live after timeout",
        {hour_disp, minute_disp, temp_disp}, {5'd10, 6'd0, 16'h3330});
    chk(pwm_en == 1'b0 && pwm_period == 16'd0, "R10 buzzer off after timeout", pwm_period, 0);

    // R11: chime on the same edge as a completed byte
    tick(6'd59);
    minute_in = 6'd0;
    fork
      send_frame(8'h44, 1'b1);
      begin
        @(negedge clk);
        repeat (9 * B + H + 4) @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
      end
    join
    chk(pwm_period == 16'h4400 && pwm_en, "R11 byte wins collision", pwm_period, 16'h4400);
    begin
      bit line_ok = 1'b1;
      for (int i = 0; i < 3 * B; i++) begin
        @(negedge clk);
        if (tx_line != 1'b1) line_ok = 1'b0;
      end
      chk(line_ok, "R11 no report on collision", line_ok, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule